// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is one bank of 32 general-purpose lines, grouped as four 8-bit ports named A, B, C and D. Software reaches it through a small window of 32-bit words with per-byte write enables. Each line has a direction bit and an output latch, and software can read back the pin level. A bit register for pin multiplexing is stored and read back, but it does not drive anything.

Each input passes through a synchronizer. The bank then detects rising and falling transitions on every line. A 2-bit code per line selects which transitions are enabled, and an enabled transition latches a per-line status bit. Software clears a status bit by writing 1 to it. The OR of all status bits drives one interrupt output. There is no level-sensitive mode.

A parameter sets how many lines are active, from 1 to 32. Lines at or above that count are inert.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous active-low reset, every direction bit, output bit, enable code, status bit and control bit is 0. `pin_oe` and `irq` are also low.
- R2: Registers sit at word-aligned byte addresses: control 0x00, direction 0x08, data 0x0C, status 0x10, enable codes for ports A/B at 0x14, and enable codes for ports C/D at 0x18. Address 0x04 reads 0 and ignores writes. The control register reads back what was written and has no effect on `pin_out` or `pin_oe`.
- R3: In the one-bit-per-line registers, line i is word bit (3 - i/8)*8 + i%8, so port A is bits 31:24. `bus_be[k]` enables bits 8k+7:8k. A lane that is not enabled keeps its old contents.
- R4: `pin_oe[i]` equals direction bit i (1 = output, 0 = input). `pin_out[i]` equals output latch bit i.
- R5: Reading the data register returns the output latch for output lines and the synchronized pin level for input lines.
- R6: Each line has a 2-bit code: 0 = no edge, 1 = falling, 2 = rising, 3 = both. In each enable word, bits 31:16 hold the first port of the pair and bits 15:0 hold the second. Line j of a port uses bits 2j+1:2j of its half.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: If an enabled edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when at least one status bit is set.
- R10: Lines at index NLINES or above read 0 in every register, ignore writes, never set status, and drive `pin_oe` and `pin_out` low.
- R11: Suppose a pin changes before rising clock edge k. Its status bit is set after edge k+2, and it is still clear after edge k+1.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address in the window (word-aligned) |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| pin_in | input | 32 | Pad input levels, indexed by line |
| pin_out | output | 32 | Output latch, indexed by line |
| pin_oe | output | 32 | Output enables, indexed by line |
| irq | output | 1 | OR of all status bits |

## Verification
The hardest case to reach from the ports is a new enabled edge landing on a status bit in the exact cycle that a write-1-to-clear targets it. The stimulus counts the synchronizer stages from the moment it changes the pin. It then places the clearing write so that its clock edge coincides with the edge latch, and reads the status back afterwards. The same cycle count is used to show that the latency is exact: status is checked as still clear one cycle before it must be set.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
// Shared constants, enumerations and word/line mapping helpers for the GPIO bank.
// Assumes a fixed bank of 32 lines in four 8-bit ports, port A at the most
// significant byte of each 32-bit register word.
package gpio_bank_pkg;

    localparam int BANK_W  = 32;
    localparam int PORT_W  = 8;
    localparam int NPORTS  = BANK_W / PORT_W;
    localparam int CODE_W  = 2 * BANK_W;

    // Word index = byte address bits 4:2
    typedef enum logic [2:0] {
        WI_CTRL  = 3'd0,
        WI_RSVD  = 3'd1,
        WI_DIR   = 3'd2,
        WI_DATA  = 3'd3,
        WI_STAT  = 3'd4,
        WI_EN_AB = 3'd5,
        WI_EN_CD = 3'd6,
        WI_NONE  = 3'd7
    } word_idx_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    // Line-indexed vector -> register word (port A in bits 31:24)
    function automatic logic [31:0] lines_to_word(input logic [31:0] l);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < BANK_W; i++)
            w[(NPORTS - 1 - i / PORT_W) * PORT_W + (i % PORT_W)] = l[i];
        return w;
    endfunction

    // Register word -> line-indexed vector
    function automatic logic [31:0] word_to_lines(input logic [31:0] w);
        logic [31:0] l;
        l = '0;
        for (int i = 0; i < BANK_W; i++)
            l[i] = w[(NPORTS - 1 - i / PORT_W) * PORT_W + (i % PORT_W)];
        return l;
    endfunction

    // 16 line codes of a port pair (line-ordered) -> register word
    function automatic logic [31:0] codes_to_word(input logic [31:0] c);
        logic [31:0] w;
        for (int j = 0; j < PORT_W; j++) begin
            w[16 + 2 * j +: 2] = c[2 * j +: 2];
            w[2 * j +: 2]      = c[2 * (PORT_W + j) +: 2];
        end
        return w;
    endfunction

    // Register word -> 16 line codes of a port pair
    function automatic logic [31:0] word_to_codes(input logic [31:0] w);
        logic [31:0] c;
        for (int j = 0; j < PORT_W; j++) begin
            c[2 * j +: 2]            = w[16 + 2 * j +: 2];
            c[2 * (PORT_W + j) +: 2] = w[2 * j +: 2];
        end
        return c;
    endfunction

    // Replace the enabled byte lanes of old_w with new_w
    function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                                input logic [31:0] new_w,
                                                input logic [3:0]  be);
        logic [31:0] r;
        r = old_w;
        for (int b = 0; b < 4; b++)
            if (be[b]) r[8 * b +: 8] = new_w[8 * b +: 8];
        return r;
    endfunction

    // Expand a per-line mask to a per-code-bit mask
    function automatic logic [63:0] spread_mask(input logic [31:0] m);
        logic [63:0] r;
        for (int i = 0; i < BANK_W; i++) r[2 * i +: 2] = {2{m[i]}};
        return r;
    endfunction

    // Mask of active lines for a given line count
    function automatic logic [31:0] active_mask(input int n);
        logic [31:0] r;
        for (int i = 0; i < BANK_W; i++) r[i] = (i < n);
        return r;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Input synchronizer and edge detector for a vector of pad inputs.
// Each bit passes through STAGES flops; the last stage is compared with
// its previous value to produce one-cycle rise and fall pulses.
// Assumes pads are asynchronous to clk and STAGES >= 2.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] stg [STAGES];
    logic [WIDTH-1:0] prev_q;

    // First stage samples the pad
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    // Remaining stages of the synchronizer chain
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    // Previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg[STAGES-1];
    end

    assign lvl  = stg[STAGES-1];
    assign rise = stg[STAGES-1] & ~prev_q;
    assign fall = ~stg[STAGES-1] & prev_q;

endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
// Per-line interrupt status: qualifies rise/fall pulses with the 2-bit
// edge code of each line and holds the result until cleared by software.
// A set and a clear on the same bit in the same cycle leave it set.
module gpio_irq_status #(
    parameter int          WIDTH = 32,
    parameter logic [31:0] ACT   = 32'hFFFF_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   rise,
    input  logic [WIDTH-1:0]   fall,
    input  logic [2*WIDTH-1:0] codes,
    input  logic [WIDTH-1:0]   clr,
    output logic [WIDTH-1:0]   hit,
    output logic [WIDTH-1:0]   stat
);

    logic [WIDTH-1:0] stat_q;

    // Per-line qualification of edges by the line's code
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        assign hit[g] = ACT[g] & ((codes[2*g+1] & rise[g]) | (codes[2*g] & fall[g]));
    end

    // Status latch: new edges dominate the write-1-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | hit;
    end

    assign stat = stat_q;

endmodule

// File: rtl/gpio_bus_regs.sv
`timescale 1ns/1ps
// Register window of the GPIO bank: address decode, byte-lane writes,
// storage of control/direction/output/edge codes, status clear mask and
// combinational read mux. Lines at or above NLINES are held at zero.
// Assumes word-aligned accesses; misaligned or out-of-window ones are ignored.
module gpio_bus_regs
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] lvl,
    input  logic [31:0] stat,
    output logic [31:0] dir,
    output logic [31:0] dout,
    output logic [63:0] codes,
    output logic [31:0] clr
);

    localparam logic [31:0] ACT  = active_mask(NLINES);
    localparam logic [63:0] ACT2 = spread_mask(ACT);

    logic [31:0] ctrl_q, dir_q, dout_q;
    logic [63:0] codes_q;
    word_idx_e   widx;
    logic        acc_ok, wr_go;
    logic [31:0] lane_mask;

    // Decode of the word being accessed
    always_comb begin
        widx   = word_idx_e'(bus_addr[4:2]);
        acc_ok = bus_en && (bus_addr[1:0] == 2'b00) && (widx != WI_NONE);
        wr_go  = acc_ok && bus_we;
        for (int b = 0; b < 4; b++) lane_mask[8*b +: 8] = {8{bus_be[b]}};
    end

    // Register storage with byte-lane merge and line masking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            dir_q   <= '0;
            dout_q  <= '0;
            codes_q <= '0;
        end else if (wr_go) begin
            case (widx)
                WI_CTRL:  ctrl_q <= word_to_lines(merge_lanes(lines_to_word(ctrl_q), bus_wdata, bus_be)) & ACT;
                WI_DIR:   dir_q  <= word_to_lines(merge_lanes(lines_to_word(dir_q), bus_wdata, bus_be)) & ACT;
                WI_DATA:  dout_q <= word_to_lines(merge_lanes(lines_to_word(dout_q), bus_wdata, bus_be)) & ACT;
                WI_EN_AB: codes_q[31:0]  <= word_to_codes(merge_lanes(codes_to_word(codes_q[31:0]),
                                                                      bus_wdata, bus_be)) & ACT2[31:0];
                WI_EN_CD: codes_q[63:32] <= word_to_codes(merge_lanes(codes_to_word(codes_q[63:32]),
                                                                      bus_wdata, bus_be)) & ACT2[63:32];
                default: ;
            endcase
        end
    end

    // Write-1-to-clear mask for the status latch
    always_comb begin
        clr = '0;
        if (wr_go && widx == WI_STAT)
            clr = word_to_lines(bus_wdata & lane_mask) & ACT;
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (acc_ok && !bus_we) begin
            case (widx)
                WI_CTRL:  bus_rdata = lines_to_word(ctrl_q);
                WI_DIR:   bus_rdata = lines_to_word(dir_q);
                WI_DATA:  bus_rdata = lines_to_word(((dir_q & dout_q) | (~dir_q & lvl)) & ACT);
                WI_STAT:  bus_rdata = lines_to_word(stat & ACT);
                WI_EN_AB: bus_rdata = codes_to_word(codes_q[31:0]);
                WI_EN_CD: bus_rdata = codes_to_word(codes_q[63:32]);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign dir   = dir_q;
    assign dout  = dout_q;
    assign codes = codes_q;

endmodule

// File: rtl/gpio_edge_bank.sv
`timescale 1ns/1ps
// Top of the GPIO bank: ties the register window, the input synchronizer
// and the status logic together and drives the combined interrupt.
// Assumes 1 <= NLINES <= 32 and SYNC_STAGES >= 2.
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NLINES      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe,
    output logic        irq
);

    localparam logic [31:0] ACT = active_mask(NLINES);

    logic [31:0] lvl_w, rise_w, fall_w, dir_w, dout_w, clr_w, hit_w, stat_w;
    logic [63:0] codes_w;

    gpio_bus_regs #(.NLINES(NLINES)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lvl       (lvl_w),
        .stat      (stat_w),
        .dir       (dir_w),
        .dout      (dout_w),
        .codes     (codes_w),
        .clr       (clr_w)
    );

    gpio_in_sync #(.WIDTH(BANK_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in & ACT),
        .lvl   (lvl_w),
        .rise  (rise_w),
        .fall  (fall_w)
    );

    gpio_irq_status #(.WIDTH(BANK_W), .ACT(ACT)) stat_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rise  (rise_w),
        .fall  (fall_w),
        .codes (codes_w),
        .clr   (clr_w),
        .hit   (hit_w),
        .stat  (stat_w)
    );

    assign pin_out = dout_w;
    assign pin_oe  = dir_w;
    assign irq     = |stat_w;

endmodule

// File: rtl/gpio_edge_bank_chk.sv
`timescale 1ns/1ps
// Checker for gpio_edge_bank, bound into every instance of the top.
// Relates the qualified edge pulses, the status latch, the bus and the outputs.
module gpio_edge_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [4:0]  bus_addr,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_wdata,
    input logic [31:0] pin_out,
    input logic [31:0] pin_oe,
    input logic        irq,
    input logic [31:0] hit,
    input logic [31:0] stat
);

    localparam logic [31:0] ACT = active_mask(NLINES);

    // R1: one cycle after reset, outputs are quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && !irq));

    // R7: a full clear with no edge empties the status
    a_r7_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == 5'h10 && bus_be == 4'hF &&
         bus_wdata == 32'hFFFF_FFFF && hit == '0) |=> (stat == '0));

    // R8: an enabled edge always lands in status, even against a clear
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((stat & $past(hit)) == $past(hit)));

    // R6: status bits only rise where an enabled edge occurred
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(hit)) == '0));

    // R9: the interrupt only rises after an enabled edge
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit != '0));

    // R10: inactive lines stay inert
    a_r10_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | pin_out | stat) & ~ACT) == '0);

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NLINES(NLINES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .hit       (hit_w),
    .stat      (stat_w)
);

// File: tb/gpio_edge_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rdata, rdata_n24, pin_out, pin_oe, pin_out_n24, pin_oe_n24;
    logic        irq, irq_n24;
    int          total = 0, bad = 0;

    always #2.5 clk = ~clk;

    gpio_edge_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    gpio_edge_bank #(.NLINES(24)) dut_n24_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_n24), .pin_in(pin_in), .pin_out(pin_out_n24),
        .pin_oe(pin_oe_n24), .irq(irq_n24)
    );

    typedef struct packed {
        logic [4:0]  addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] rexp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{5'h08, 4'hF, 32'h1234_5678, 32'h1234_5678},
        '{5'h08, 4'h4, 32'hAAAA_AAAA, 32'h12AA_5678},
        '{5'h00, 4'hF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{5'h14, 4'hF, 32'hFFFF_0000, 32'hFFFF_0000},
        '{5'h18, 4'h1, 32'h0000_00C3, 32'h0000_00C3},
        '{5'h04, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},
        '{5'h08, 4'h0, 32'hFFFF_FFFF, 32'h12AA_5678},
        '{5'h08, 4'hF, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d, output logic [31:0] d24);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = rdata; d24 = rdata_n24;
        bus_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r, r24;
        wait_cyc(4);
        check("R1 pin_oe in reset", pin_oe, 32'h0);
        check("R1 irq in reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        bus_read(5'h08, r, r24); check("R1 dir", r, 32'h0);
        bus_read(5'h10, r, r24); check("R1 status", r, 32'h0);
        bus_read(5'h14, r, r24); check("R1 codes AB", r, 32'h0);
        bus_read(5'h00, r, r24); check("R1 ctrl", r, 32'h0);

        // R2/R3 table of writes and readbacks
        for (int v = 0; v < NVEC; v++) begin
            bus_write(TBL[v].addr, TBL[v].be, TBL[v].wdata);
            bus_read(TBL[v].addr, r, r24);
            check($sformatf("R2/R3 row %0d", v), r, TBL[v].rexp);
        end
        // R2: ctrl still DEADBEEF but no effect on pins
        check("R2 ctrl no effect oe", pin_oe, 32'h0);
        check("R2 ctrl no effect out", pin_out, 32'h0);
        bus_write(5'h14, 4'hF, 32'h0);
        bus_write(5'h18, 4'hF, 32'h0);

        // R4/R5 direction and data
        bus_write(5'h08, 4'hF, 32'h0000_00FF);
        bus_write(5'h0C, 4'hF, 32'hFFFF_FFFF);
        check("R4 pin_oe", pin_oe, 32'hFF00_0000);
        check("R4 pin_out", pin_out, 32'hFFFF_FFFF);
        bus_read(5'h0C, r, r24); check("R5 data outputs", r, 32'h0000_00FF);
        pin_in[0] = 1'b1; wait_cyc(3);
        bus_read(5'h0C, r, r24); check("R5 data input line0", r, 32'h0100_00FF);
        bus_read(5'h10, r, r24); check("R6 code0 no status", r, 32'h0);
        pin_in[0] = 1'b0; wait_cyc(3);
        bus_write(5'h08, 4'hF, 32'h0);
        bus_write(5'h0C, 4'hF, 32'h0);

        // R6 codes: line0 rising, line9 both, line16 falling
        bus_write(5'h14, 4'hF, 32'h0002_000C);
        bus_write(5'h18, 4'hF, 32'h0001_0000);
        // R11 latency on line 0
        pin_in[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R11 not yet set", {31'b0, irq}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R11 set after third edge", {31'b0, irq}, 32'h1);
        bus_read(5'h10, r, r24); check("R6 rising line0", r, 32'h0100_0000);
        bus_write(5'h10, 4'hF, 32'h0100_0000);
        bus_read(5'h10, r, r24); check("R7 clear", r, 32'h0);
        check("R9 irq low", {31'b0, irq}, 32'h0);
        pin_in[0] = 1'b0; wait_cyc(4);
        bus_read(5'h10, r, r24); check("R6 rising ignores fall", r, 32'h0);
        pin_in[9] = 1'b1; wait_cyc(4);
        bus_read(5'h10, r, r24); check("R6 both rise line9", r, 32'h0002_0000);
        check("R9 irq high", {31'b0, irq}, 32'h1);
        bus_write(5'h10, 4'hF, 32'hFFFD_FFFF);
        bus_read(5'h10, r, r24); check("R7 zero keeps", r, 32'h0002_0000);

        // R8: falling edge on line 9 collides with clear
        pin_in[9] = 1'b0;
        @(negedge clk); @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 5'h10; bus_be = 4'hF; bus_wdata = 32'h0002_0000;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        bus_read(5'h10, r, r24); check("R8 edge wins", r, 32'h0002_0000);
        bus_write(5'h10, 4'hF, 32'h0002_0000);
        bus_read(5'h10, r, r24); check("R7 clear after R8", r, 32'h0);

        pin_in[16] = 1'b1; wait_cyc(4);
        bus_read(5'h10, r, r24); check("R6 falling ignores rise", r, 32'h0);
        pin_in[16] = 1'b0; wait_cyc(4);
        bus_read(5'h10, r, r24); check("R6 falling line16", r, 32'h0000_0100);
        bus_write(5'h10, 4'hF, 32'hFFFF_FFFF);
        pin_in[24] = 1'b1; wait_cyc(4);
        bus_read(5'h10, r, r24); check("R6 code0 line24", r, 32'h0);

        // R10 on the 24-line instance
        bus_write(5'h08, 4'hF, 32'hFFFF_FFFF);
        bus_read(5'h08, r, r24);
        check("R10 full dir", r, 32'hFFFF_FFFF);
        check("R10 n24 dir", r24, 32'hFFFF_FF00);
        check("R10 n24 pin_oe", pin_oe_n24, 32'h00FF_FFFF);
        bus_write(5'h18, 4'hF, 32'hFFFF_FFFF);
        bus_read(5'h18, r, r24); check("R10 n24 codes", r24, 32'hFFFF_0000);
        pin_in[24] = 1'b0; wait_cyc(4);
        bus_read(5'h10, r, r24); check("R10 n24 status", r24, 32'h0);
        check("R10 n24 irq", {31'b0, irq_n24}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule